// File: doc/BRIEF.md
# Multi-Channel Trigger Delay Bank

A bank of ten identical delay channels that all draw on the same four external trigger lines. Each channel chooses one of the four lines, waits a programmed number of clock ticks after that line rises, and then emits a single-cycle output pulse. The pulse is emitted only if the channel's enable bit is set. Each emitted pulse also sets a sticky detect flag, which software can read back. At a 200 MHz core clock, one tick is 5 ns, so the 8-bit delay field spans 0 to 1.275 us.

Software controls each channel through one 16-bit word on a small synchronous register bus. The bus has a byte address, a write strobe, a read strobe and write/read data. Writing a channel's word sets its delay, source and enable together. The same write also clears that channel's detect flag and cancels any countdown in progress. The trigger lines are asynchronous to the core clock. Each line is resynchronised by two flops and then edge-detected before any channel sees it.

Top module: `trig_delay_bank`

## Requirements
- R1: After reset, every trig_out bit is 0, bus_rdata is 0, and every channel word reads as 0.
- R2: Channel word layout: bits 7:0 are the delay N, bits 9:8 the source code, and bit 10 the enable. These fields read back as last written. Bit 11 reads the detect flag. Bits 15:12 read 0, and written bits 15:11 are dropped.
- R3: Channel n occupies byte address 0x20 + 2n for n = 0..9. Writes to any other address (odd, below 0x20 or above 0x32) change no channel, and reads of them return 0.
- R4: bus_rdata carries the addressed word in the cycle after the one where bus_rd is high, and is 0 in every other cycle.
- R5: Source code s (0..3) makes the channel respond to trig_in[s] only; edges on the other three lines have no effect on it.
- R6: If trig_in[s] is first high at rising clock edge k, an enabled channel with delay N raises its trig_out bit for exactly one cycle, starting just after clock edge k+2+N. A delay of 0 is therefore valid.
- R7: A channel whose enable bit is 0 produces no output pulse and does not set its detect flag.
- R8: Rising edges that arrive while a channel is counting down are ignored; one trigger yields exactly one pulse.
- R9: The detect flag sets in the same cycle as the channel's output pulse. It stays set until that channel's word is written.
- R10: Writing a channel's word during a countdown cancels it: no pulse follows from that trigger.
- R11: Channels are independent: several channels on one source each fire after their own delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (one delay tick per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 4 | Asynchronous external trigger lines |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| trig_out | output | 10 | Per-channel delayed trigger pulses |

## Verification
The in-line assertions check several rules on every cycle:
- a pulse only follows an enabled channel,
- the detect flag accompanies every pulse and holds until a write,
- a write leaves the channel idle and clear,
- countdowns step down by one without being restarted,
- pulses and edges last one cycle,
- read data is zero outside a read response.

Only the bench scenarios can show the end-to-end latency for every delay value from 0 to 255, through the synchronizer. The same applies to the address map over the full address space, to source selection against the other lines, and to ignored retriggers and aborted countdowns as seen at trig_out.

// File: rtl/trig_delay_pkg.sv
package trig_delay_pkg;
  localparam int N_SRC   = 4;
  localparam int SEL_W   = $clog2(N_SRC);
  localparam int DLY_W   = 8;
  localparam int WORD_W  = 16;
  localparam int SEL_LSB = DLY_W;
  localparam int EN_BIT  = SEL_LSB + SEL_W;
  localparam int DET_BIT = EN_BIT + 1;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic [DLY_W-1:0] dly;
  } chan_cfg_t;

  function automatic logic [WORD_W-1:0] pack_word(chan_cfg_t c, logic det);
    logic [WORD_W-1:0] w;
    w = '0;
    w[DLY_W-1:0]             = c.dly;
    w[SEL_LSB +: SEL_W]      = c.sel;
    w[EN_BIT]                = c.en;
    w[DET_BIT]               = det;
    return w;
  endfunction
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge
  import trig_delay_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] raw_in,
  output logic [N_SRC-1:0] rise_o
);
  logic [N_SRC-1:0] meta_q, sync_q, prev_q;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[s] <= 1'b0;
        sync_q[s] <= 1'b0;
        prev_q[s] <= 1'b0;
      end else begin
        meta_q[s] <= raw_in[s];
        sync_q[s] <= meta_q[s];
        prev_q[s] <= sync_q[s];
      end
    end

    assign rise_o[s] = sync_q[s] & ~prev_q[s];

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[s] |=> !rise_o[s]); // R6
  end
endmodule

// File: rtl/trig_delay_chan.sv
module trig_delay_chan
  import trig_delay_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_rise,
  input  logic             wr_sel,
  input  chan_cfg_t        wr_cfg,
  output chan_cfg_t        cfg_o,
  output logic             det_o,
  output logic             pulse_o
);
  chan_cfg_t        cfg_q, cfg_d;
  logic             busy_q, busy_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             det_q, det_d;
  logic             pulse_q, pulse_d;
  logic             edge_sel, fire, last_tick;

  always_comb begin
    edge_sel  = src_rise[cfg_q.sel];
    last_tick = busy_q & (cnt_q == DLY_W'(1));
    fire      = (~busy_q & edge_sel & (cfg_q.dly == '0)) | last_tick;

    cfg_d  = cfg_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (wr_sel) begin
      cfg_d  = wr_cfg;
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - DLY_W'(1);
      busy_d = ~last_tick;
    end else if (edge_sel && (cfg_q.dly != '0)) begin
      busy_d = 1'b1;
      cnt_d  = cfg_q.dly;
    end

    pulse_d = fire & cfg_q.en & ~wr_sel;
    det_d   = wr_sel ? 1'b0 : (det_q | pulse_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      det_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      det_q   <= det_d;
      pulse_q <= pulse_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign det_o   = det_q;
  assign pulse_o = pulse_q;

  AST_PULSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(cfg_q.en)); // R7
  AST_DET_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> det_q); // R9
  AST_DET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    det_q && !wr_sel |=> det_q); // R9
  AST_WR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_sel) |-> !busy_q && !pulse_q && !det_q); // R10
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R6
  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !wr_sel && (cnt_q != DLY_W'(1)) |=> busy_q && (cnt_q == $past(cnt_q) - DLY_W'(1))); // R8
  AST_BUSY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q != '0); // R8
endmodule

// File: rtl/trig_reg_port.sv
module trig_reg_port
  import trig_delay_pkg::*;
#(
  parameter int NUM_CH   = 10,
  parameter int ADDR_W   = 8,
  parameter int REG_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] words [NUM_CH],
  output logic [NUM_CH-1:0] wr_sel_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-2:0] CH_LIM = (ADDR_W-1)'(NUM_CH);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-2:0] idx;
  logic              hit;
  logic [WORD_W-1:0] rdata_q, rdata_d;

  always_comb begin
    off = bus_addr - BASE_A;
    idx = off[ADDR_W-1:1];
    hit = (bus_addr >= BASE_A) && !bus_addr[0] && (idx < CH_LIM);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign wr_sel_o[c] = bus_wr & hit & (idx == (ADDR_W-1)'(c));
  end

  always_comb begin
    rdata_d = '0;
    if (bus_rd && hit) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (idx == (ADDR_W-1)'(c)) rdata_d = words[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> rdata_q == '0); // R4
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel_o)); // R3
  AST_RD_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_q[WORD_W-1:DET_BIT+1] == '0); // R2
endmodule

// File: rtl/trig_delay_bank.sv
module trig_delay_bank
  import trig_delay_pkg::*;
#(
  parameter int NUM_CH   = 10,
  parameter int ADDR_W   = 8,
  parameter int REG_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  trig_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] trig_out
);
  logic              rst_meta_q, rst_sync_q;
  logic [N_SRC-1:0]  src_rise;
  logic [NUM_CH-1:0] wr_sel;
  logic [WORD_W-1:0] words [NUM_CH];
  chan_cfg_t         wr_cfg;
  logic              unused_wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    wr_cfg.dly = bus_wdata[DLY_W-1:0];
    wr_cfg.sel = bus_wdata[SEL_LSB +: SEL_W];
    wr_cfg.en  = bus_wdata[EN_BIT];
  end
  assign unused_wbits = ^bus_wdata[WORD_W-1:EN_BIT+1];

  trig_sync_edge u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .raw_in (trig_in),
    .rise_o (src_rise)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_cfg_t cfg_c;
    logic      det_c;
    trig_delay_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .src_rise (src_rise),
      .wr_sel   (wr_sel[c]),
      .wr_cfg   (wr_cfg),
      .cfg_o    (cfg_c),
      .det_o    (det_c),
      .pulse_o  (trig_out[c])
    );
    assign words[c] = pack_word(cfg_c, det_c);
  end

  trig_reg_port #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .REG_BASE (REG_BASE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .words    (words),
    .wr_sel_o (wr_sel),
    .rdata_o  (bus_rdata)
  );
endmodule

// File: tb/trig_delay_bank_tb_top.sv
`timescale 1ns/1ps
module trig_delay_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  trig_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [9:0]  trig_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int firsts [10];
  int counts [10];

  always #2 clk = ~clk;

  trig_delay_bank dut_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .trig_out(trig_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input int addr, input int data);
    @(negedge clk);
    bus_addr = 8'(addr); bus_wdata = 16'(data); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(input int addr, output int data);
    @(negedge clk);
    bus_addr = 8'(addr); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    data = int'(bus_rdata);
  endtask

  // Raise trig_in[src] for two cycles, watch all outputs for win cycles.
  // Optional retrigger at cycle rt and register write at cycle ab (0 = none).
  task automatic fire_watch(input int src, input int win, input int rt,
                            input int ab, input int ab_addr, input int ab_data);
    for (int c = 0; c < 10; c++) begin firsts[c] = -1; counts[c] = 0; end
    @(negedge clk);
    trig_in[src] = 1'b1;
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      for (int c = 0; c < 10; c++) begin
        if (trig_out[c]) begin
          counts[c]++;
          if (firsts[c] < 0) firsts[c] = i;
        end
      end
      bus_wr = 1'b0;
      if (i == 2) trig_in[src] = 1'b0;
      if (rt != 0 && i == rt) trig_in[src] = 1'b1;
      if (rt != 0 && i == rt + 2) trig_in[src] = 1'b0;
      if (ab != 0 && i == ab) begin
        bus_addr = 8'(ab_addr); bus_wdata = 16'(ab_data); bus_wr = 1'b1;
      end
    end
    bus_wr = 1'b0;
  endtask

  initial begin
    int rd;
    int w;
    repeat (3) @(negedge clk);
    check(trig_out == '0, "R1 trig_out in reset", int'(trig_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(trig_out == '0, "R1 trig_out after reset", int'(trig_out), 0);
    check(bus_rdata == '0, "R1 rdata after reset", int'(bus_rdata), 0);
    for (int c = 0; c < 10; c++) begin
      reg_read(32 + 2*c, rd);
      check(rd == 0, "R1 channel word reset", rd, 0);
    end

    // R2/R3 register map sweep
    for (int c = 0; c < 10; c++) reg_write(32 + 2*c, 16'hF800 | (c * 97 + 5) & 16'h07FF | ((c & 1) << 10));
    for (int a = 0; a < 256; a++) begin
      if (a >= 32 && a < 52 && (a % 2) == 0) continue;
      reg_write(a, 16'hFFFF);
    end
    for (int a = 0; a < 256; a++) begin
      int c;
      int exp;
      c = (a - 32) / 2;
      exp = 0;
      if (a >= 32 && a < 52 && (a % 2) == 0)
        exp = ((c * 97 + 5) & 16'h07FF | ((c & 1) << 10)) & 16'h07FF;
      reg_read(a, rd);
      check(rd == exp, (exp != 0) ? "R2 field readback" : "R3 unmapped reads zero", rd, exp);
    end
    // R4: rdata returns to zero the cycle after a read response
    @(negedge clk);
    check(bus_rdata == '0, "R4 rdata idle", int'(bus_rdata), 0);

    // R6/R5 latency sweep over every delay value on channel 0
    for (int c = 1; c < 10; c++) reg_write(32 + 2*c, 0);
    for (int n = 0; n < 256; n++) begin
      int s;
      s = n % 4;
      reg_write(32, (1 << 10) | (s << 8) | n);
      fire_watch(s, n + 10, 0, 0, 0, 0);
      check(firsts[0] == n + 3, "R6 latency", firsts[0], n + 3);
      check(counts[0] == 1, "R6 single pulse", counts[0], 1);
    end

    // R5: other sources ignored
    reg_write(32, (1 << 10) | (1 << 8) | 2);
    for (int s = 0; s < 4; s++) begin
      if (s == 1) continue;
      fire_watch(s, 20, 0, 0, 0, 0);
      check(counts[0] == 0, "R5 unselected source ignored", counts[0], 0);
    end
    reg_read(32, rd);
    check(rd == 16'h0502, "R5 no detect from other source", rd, 16'h0502);

    // R9: detect set by pulse, sticky, cleared by write
    fire_watch(1, 20, 0, 0, 0, 0);
    check(firsts[0] == 5, "R9 pulse", firsts[0], 5);
    repeat (10) @(negedge clk);
    reg_read(32, rd);
    check(rd == 16'h0D02, "R9 detect sticky", rd, 16'h0D02);
    reg_write(32, 16'h0502);
    reg_read(32, rd);
    check(rd == 16'h0502, "R9 detect cleared by write", rd, 16'h0502);

    // R7: disabled channel gives no pulse, no detect
    reg_write(32, (0 << 10) | (3 << 8) | 6);
    fire_watch(3, 30, 0, 0, 0, 0);
    check(counts[0] == 0, "R7 disabled no pulse", counts[0], 0);
    reg_read(32, rd);
    check(rd == 16'h0306, "R7 disabled no detect", rd, 16'h0306);

    // R8: retrigger during countdown ignored
    reg_write(32, (1 << 10) | (2 << 8) | 20);
    fire_watch(2, 70, 8, 0, 0, 0);
    check(counts[0] == 1, "R8 one pulse per countdown", counts[0], 1);
    check(firsts[0] == 23, "R8 first pulse timing", firsts[0], 23);

    // R10: write during countdown aborts it
    w = (1 << 10) | (0 << 8) | 30;
    reg_write(32, w);
    fire_watch(0, 70, 0, 12, 32, w);
    check(counts[0] == 0, "R10 aborted countdown", counts[0], 0);
    reg_read(32, rd);
    check(rd == w, "R10 no detect after abort", rd, w);

    // R11: all channels on one source with distinct delays
    for (int c = 0; c < 10; c++) reg_write(32 + 2*c, (1 << 10) | (2 << 8) | (4*c + 1));
    fire_watch(2, 60, 0, 0, 0, 0);
    for (int c = 0; c < 10; c++) begin
      check(firsts[c] == 4*c + 4, "R11 per-channel delay", firsts[c], 4*c + 4);
      check(counts[c] == 1, "R11 per-channel single pulse", counts[c], 1);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule